// File: doc/BRIEF.md
# Packed SIMD Multiply-Accumulate Unit

This block is a lane-parallel multiply-accumulate engine for packed integer vectors. A single datapath splits its operands into 8-, 16- or 32-bit lanes. It multiplies matching lanes of two source vectors and then adds each product to the matching lane of an accumulator vector, or subtracts it. The block writes the updated accumulator into a result register.

Two destination shapes are offered:

- **Normal form.** Each result lane is as wide as a source lane, and the sum wraps.
- **Widening form.** The block reads one 64-bit chunk of each source. Each result lane is twice as wide as a source lane and accumulates the full signed or unsigned product.

A normal operation covers one 64-bit chunk or two consecutive chunks (128 bits).

A caller presents the operands and the control fields together with a one-cycle `inValid` pulse. The block answers one cycle later with a one-cycle `outValid` pulse and the new `result`. A configuration the block cannot perform is reported on `cfgError` and leaves the result register untouched.

Top module: `packed_mac`

## Requirements
- R1: `sizeSel` picks the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes and 2'b10 gives 32-bit lanes. Lane e of a 64-bit chunk occupies bits [e*esize +: esize]. Chunk r occupies bits [64*r +: 64] of the 128-bit vectors.
- R2: `subSel`=0 adds each lane product to the accumulator lane. `subSel`=1 subtracts it.
- R3: In normal form (`wideSel`=0), each result lane equals (acc lane ± a lane * b lane) mod 2^esize, so a subtraction below zero wraps. `unsignedSel` has no effect on the result bits.
- R4: In normal form, `quadSel`=1 processes both 64-bit chunks. `quadSel`=0 processes only chunk 0, and result[127:64] is set to accIn[127:64].
- R5: In widening form (`wideSel`=1), sources come from srcA[63:0] and srcB[63:0]. The result has 64/esize lanes of 2*esize bits at [e*2*esize +: 2*esize], each equal to (acc lane ± full product) mod 2^(2*esize).
- R6: In widening form, `unsignedSel`=0 treats source lanes as two's-complement signed values. `unsignedSel`=1 treats them as unsigned.
- R7: An operation with `sizeSel`=2'b11, or with `wideSel`=1 together with `quadSel`=1, raises `cfgError` in its `outValid` cycle and leaves `result` unchanged.
- R8: `outValid` is high for exactly the one cycle after each cycle in which `inValid` is high, and never otherwise. `result` holds the new value in that cycle and keeps it until the next legal operation.
- R9: A synchronous active-high `rst` clears `result`, `outValid` and `cfgError` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | One-cycle operation request |
| sizeSel | input | 2 | Lane width code (00=8, 01=16, 10=32, 11 illegal) |
| subSel | input | 1 | 0 = multiply-accumulate, 1 = multiply-subtract |
| unsignedSel | input | 1 | Widening form: 0 = signed, 1 = unsigned |
| wideSel | input | 1 | 1 = widening destination |
| quadSel | input | 1 | 1 = process two 64-bit chunks |
| srcA | input | 128 | First source vector |
| srcB | input | 128 | Second source vector |
| accIn | input | 128 | Current accumulator vector |
| outValid | output | 1 | One-cycle result strobe |
| cfgError | output | 1 | Illegal configuration flag, valid with outValid |
| result | output | 128 | Updated accumulator register |

## Verification
Every legal combination of lane width, add/subtract, chunk count and, for the widening form, signedness is driven with random operands. The results are compared with a lane-looping model. This separates lane boundaries, chunk placement and pass-through of the upper accumulator half.

All-ones operands and most-negative lanes make the signed and unsigned widening products differ, which exposes a wrong extension. A zero accumulator minus a positive product checks the wrap below zero. Normal-form runs with `unsignedSel` toggled confirm that it has no effect.

Each illegal code is followed by a comparison of the unchanged result. This shows that the register was not written.

// File: rtl/packed_mac_pkg.sv
package packed_mac_pkg;
  localparam int CHUNK_W    = 64;
  localparam int NUM_CHUNKS = 2;
  localparam int VEC_W      = CHUNK_W * NUM_CHUNKS;
  localparam int NUM_SIZES  = 3;

  typedef enum logic [1:0] {
    SZ_8   = 2'b00,
    SZ_16  = 2'b01,
    SZ_32  = 2'b10,
    SZ_BAD = 2'b11
  } laneSize_t;

  typedef struct packed {
    logic loadResult;
    logic raiseValid;
    logic raiseError;
  } macStrobe_t;
endpackage

// File: rtl/packed_mac_ctrl.sv
module packed_mac_ctrl
  import packed_mac_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] sizeSel,
  input  logic       wideSel,
  input  logic       quadSel,
  output macStrobe_t strobe,
  output logic       outValid,
  output logic       cfgError
);
  logic cfgLegal;

  always_comb begin
    cfgLegal          = (laneSize_t'(sizeSel) != SZ_BAD) && !(wideSel && quadSel);
    strobe.loadResult = inValid && cfgLegal;
    strobe.raiseValid = inValid;
    strobe.raiseError = inValid && !cfgLegal;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      cfgError <= 1'b0;
    end else begin
      outValid <= strobe.raiseValid;
      cfgError <= strobe.raiseError;
    end
  end

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  assert_bad_size_R7: assert property (@(posedge clk) disable iff (rst)
    (inValid && sizeSel == 2'b11) |=> (cfgError && outValid));
  assert_bad_wide_quad_R7: assert property (@(posedge clk) disable iff (rst)
    (inValid && wideSel && quadSel) |=> (cfgError && outValid));
  assert_error_with_valid_R7: assert property (@(posedge clk) disable iff (rst)
    cfgError |-> outValid);
endmodule

// File: rtl/packed_mac_dp.sv
module packed_mac_dp
  import packed_mac_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  macStrobe_t       strobe,
  input  logic [1:0]       sizeSel,
  input  logic             subSel,
  input  logic             unsignedSel,
  input  logic             wideSel,
  input  logic             quadSel,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  input  logic [VEC_W-1:0] accIn,
  output logic [VEC_W-1:0] result
);
  logic [VEC_W-1:0] candNorm [NUM_SIZES];
  logic [VEC_W-1:0] candWide [NUM_SIZES];
  logic [VEC_W-1:0] nextResult;
  logic             signedMode;

  assign signedMode = !unsignedSel;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int ESZ = 8 << s;
    localparam int NL  = VEC_W / ESZ;
    localparam int WL  = CHUNK_W / ESZ;
    logic [VEC_W-1:0] normVec;
    logic [VEC_W-1:0] wideVec;

    for (genvar e = 0; e < NL; e++) begin : g_norm
      logic [ESZ-1:0]   aLane, bLane, cLane;
      logic [2*ESZ-1:0] fullProd;
      assign aLane    = srcA[e*ESZ +: ESZ];
      assign bLane    = srcB[e*ESZ +: ESZ];
      assign cLane    = accIn[e*ESZ +: ESZ];
      assign fullProd = {{ESZ{1'b0}}, aLane} * {{ESZ{1'b0}}, bLane};
      assign normVec[e*ESZ +: ESZ] = subSel ? (cLane - fullProd[ESZ-1:0])
                                            : (cLane + fullProd[ESZ-1:0]);
    end

    for (genvar e = 0; e < WL; e++) begin : g_wide
      logic [ESZ-1:0]   aLane, bLane;
      logic [2*ESZ-1:0] aExt, bExt, cLane, wideProd;
      assign aLane    = srcA[e*ESZ +: ESZ];
      assign bLane    = srcB[e*ESZ +: ESZ];
      assign aExt     = {{ESZ{signedMode & aLane[ESZ-1]}}, aLane};
      assign bExt     = {{ESZ{signedMode & bLane[ESZ-1]}}, bLane};
      assign cLane    = accIn[e*2*ESZ +: 2*ESZ];
      assign wideProd = aExt * bExt;
      assign wideVec[e*2*ESZ +: 2*ESZ] = subSel ? (cLane - wideProd) : (cLane + wideProd);
    end

    assign candNorm[s] = quadSel ? normVec
                                 : {accIn[VEC_W-1:CHUNK_W], normVec[CHUNK_W-1:0]};
    assign candWide[s] = wideVec;
  end

  always_comb begin
    case (laneSize_t'(sizeSel))
      SZ_8:    nextResult = wideSel ? candWide[0] : candNorm[0];
      SZ_16:   nextResult = wideSel ? candWide[1] : candNorm[1];
      SZ_32:   nextResult = wideSel ? candWide[2] : candNorm[2];
      default: nextResult = result;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else if (strobe.loadResult) result <= nextResult;
  end

  assert_hold_unless_load_R7: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadResult |=> $stable(result));
  assert_upper_passthru_R4: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadResult && !wideSel && !quadSel)
      |=> result[VEC_W-1:CHUNK_W] == $past(accIn[VEC_W-1:CHUNK_W]));
endmodule

// File: rtl/packed_mac.sv
module packed_mac
  import packed_mac_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [1:0]   sizeSel,
  input  logic         subSel,
  input  logic         unsignedSel,
  input  logic         wideSel,
  input  logic         quadSel,
  input  logic [127:0] srcA,
  input  logic [127:0] srcB,
  input  logic [127:0] accIn,
  output logic         outValid,
  output logic         cfgError,
  output logic [127:0] result
);
  macStrobe_t strobe;

  packed_mac_ctrl ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .sizeSel(sizeSel),
    .wideSel(wideSel), .quadSel(quadSel), .strobe(strobe),
    .outValid(outValid), .cfgError(cfgError)
  );

  packed_mac_dp dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .sizeSel(sizeSel),
    .subSel(subSel), .unsignedSel(unsignedSel), .wideSel(wideSel),
    .quadSel(quadSel), .srcA(srcA), .srcB(srcB), .accIn(accIn),
    .result(result)
  );

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (result == '0 && !outValid && !cfgError));
endmodule

// File: tb/packed_mac_tb_top.sv
module packed_mac_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [1:0]   sizeSel = '0;
  logic         subSel = 1'b0, unsignedSel = 1'b0, wideSel = 1'b0, quadSel = 1'b0;
  logic [127:0] srcA = '0, srcB = '0, accIn = '0;
  logic         outValid, cfgError;
  logic [127:0] result;

  int checks = 0;
  int failures = 0;
  logic [127:0] lastExp = '0;

  typedef struct {
    logic [127:0] res;
    logic         err;
    string        tag;
  } expItem_t;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  packed_mac dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .sizeSel(sizeSel), .subSel(subSel),
    .unsignedSel(unsignedSel), .wideSel(wideSel), .quadSel(quadSel),
    .srcA(srcA), .srcB(srcB), .accIn(accIn),
    .outValid(outValid), .cfgError(cfgError), .result(result)
  );

  function automatic logic [127:0] modelMac(input logic [1:0] sz, input logic sub,
      input logic uns, input logic wide, input logic quad,
      input logic [127:0] a, input logic [127:0] b, input logic [127:0] acc,
      input logic [127:0] prev);
    logic [127:0] res;
    logic [63:0]  m, m2, x, y, p, c, r;
    int w, n;
    if (sz == 2'b11 || (wide && quad)) return prev;
    w = 8 << sz;
    m = {64{1'b1}} >> (64 - w);
    res = acc;
    if (!wide) begin
      n = (quad ? 128 : 64) / w;
      for (int e = 0; e < n; e++) begin
        x = 64'(a >> (e*w)) & m;
        y = 64'(b >> (e*w)) & m;
        c = 64'(acc >> (e*w)) & m;
        p = (x * y) & m;
        r = (sub ? c - p : c + p) & m;
        res = (res & ~(128'(m) << (e*w))) | (128'(r) << (e*w));
      end
    end else begin
      m2 = {64{1'b1}} >> (64 - 2*w);
      n = 64 / w;
      for (int e = 0; e < n; e++) begin
        x = 64'(a >> (e*w)) & m;
        y = 64'(b >> (e*w)) & m;
        if (!uns && x[w-1]) x = x | ~m;
        if (!uns && y[w-1]) y = y | ~m;
        c = 64'(acc >> (e*2*w)) & m2;
        p = (x * y) & m2;
        r = (sub ? c - p : c + p) & m2;
        res = (res & ~(128'(m2) << (e*2*w))) | (128'(r) << (e*2*w));
      end
    end
    return res;
  endfunction

  task automatic runOp(input logic [1:0] sz, input logic sub, input logic uns,
      input logic wide, input logic quad, input logic [127:0] a,
      input logic [127:0] b, input logic [127:0] acc, input string tag);
    expItem_t it;
    @(negedge clk);
    sizeSel = sz; subSel = sub; unsignedSel = uns; wideSel = wide; quadSel = quad;
    srcA = a; srcB = b; accIn = acc; inValid = 1'b1;
    it.res = modelMac(sz, sub, uns, wide, quad, a, b, acc, lastExp);
    it.err = (sz == 2'b11) || (wide && quad);
    it.tag = tag;
    lastExp = it.res;
    expQ.push_back(it);
    @(negedge clk);
    inValid = 1'b0;
    srcA = '0; srcB = '0; accIn = '0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$random, $random, $random, $random};
  endfunction

  initial begin : monitor
    expItem_t it;
    forever begin
      @(negedge clk);
      if (!rst && outValid) begin
        if (expQ.size() == 0) begin
          checks++; failures++;
          $display("FAIL R8 unexpected outValid actual=1 expected=0");
        end else begin
          it = expQ.pop_front();
          checks++;
          if (result !== it.res) begin
            failures++;
            $display("FAIL %s result actual=%h expected=%h", it.tag, result, it.res);
          end
          checks++;
          if (cfgError !== it.err) begin
            failures++;
            $display("FAIL %s cfgError actual=%b expected=%b", it.tag, cfgError, it.err);
          end
        end
      end else if (!rst && expQ.size() != 0) begin
        checks++; failures++;
        $display("FAIL R8 outValid missing actual=0 expected=1");
        void'(expQ.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    checks++;
    if (result !== '0 || outValid !== 1'b0 || cfgError !== 1'b0) begin
      failures++;
      $display("FAIL R9 reset state actual=%h/%b/%b expected=0/0/0", result, outValid, cfgError);
    end
    rst = 1'b0;

    // R1 R2 R3 R4: normal form, every size, add/sub, one or two chunks
    for (int sz = 0; sz < 3; sz++)
      for (int sb = 0; sb < 2; sb++)
        for (int q = 0; q < 2; q++)
          for (int k = 0; k < 3; k++)
            runOp(2'(sz), sb[0], k[0], 1'b0, q[0], rnd128(), rnd128(), rnd128(),
                  "R1 R2 R3 R4 normal random");

    // R3: unsignedSel has no effect in normal form
    runOp(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, {16{8'hff}}, {16{8'h80}}, '0, "R3 normal signed code");
    runOp(2'b00, 1'b0, 1'b1, 1'b0, 1'b1, {16{8'hff}}, {16{8'h80}}, '0, "R3 normal unsigned code");
    // R3: subtraction wraps below zero
    runOp(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, {8{16'h0001}}, {8{16'h0001}}, '0, "R3 wrap below zero");
    runOp(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, {4{32'hffffffff}}, {4{32'hffffffff}}, '0, "R3 R4 all ones sub");

    // R5 R6: widening form, every size, add/sub, signed/unsigned
    for (int sz = 0; sz < 3; sz++)
      for (int sb = 0; sb < 2; sb++)
        for (int u = 0; u < 2; u++)
          for (int k = 0; k < 3; k++)
            runOp(2'(sz), sb[0], u[0], 1'b1, 1'b0, rnd128(), rnd128(), rnd128(),
                  "R5 R6 widening random");

    // R6: most negative and all-ones corners
    for (int sz = 0; sz < 3; sz++)
      for (int u = 0; u < 2; u++) begin
        runOp(2'(sz), 1'b0, u[0], 1'b1, 1'b0, {16{8'h80}}, {16{8'h80}}, '0, "R6 most negative");
        runOp(2'(sz), 1'b0, u[0], 1'b1, 1'b0, {128{1'b1}}, {16{8'h80}}, '0, "R6 ones times negative");
        runOp(2'(sz), 1'b1, u[0], 1'b1, 1'b0, {128{1'b1}}, {128{1'b1}}, '0, "R5 R6 all ones sub");
      end

    // R7: illegal codes leave result unchanged
    runOp(2'b10, 1'b0, 1'b0, 1'b0, 1'b1, rnd128(), rnd128(), rnd128(), "R7 setup");
    runOp(2'b11, 1'b0, 1'b0, 1'b0, 1'b1, rnd128(), rnd128(), rnd128(), "R7 size code 11");
    runOp(2'b00, 1'b1, 1'b0, 1'b1, 1'b1, rnd128(), rnd128(), rnd128(), "R7 wide with quad");
    runOp(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, rnd128(), rnd128(), rnd128(), "R7 recovery");

    // R8: result holds between operations, no stray outValid
    repeat (5) @(negedge clk);
    checks++;
    if (result !== lastExp) begin
      failures++;
      $display("FAIL R8 hold actual=%h expected=%h", result, lastExp);
    end

    // R9: reset mid-run clears the result
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; lastExp = '0;
    checks++;
    if (result !== '0 || outValid !== 1'b0 || cfgError !== 1'b0) begin
      failures++;
      $display("FAIL R9 reset mid-run actual=%h/%b/%b expected=0/0/0", result, outValid, cfgError);
    end

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R8 pending results actual=%0d expected=0", expQ.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule